// File: doc/BRIEF.md
# Seven-Instruction Word Processor Core

This block is a single-cycle, 32-bit load/store processor core. Each rising clock edge retires one instruction. The instruction is fetched from a word-wide instruction port whose address is the program counter. It is decoded and then executes an add, a subtract, an add-immediate, a word load, a word store, or one of two zero-test branches. The core holds the program counter and a 32-entry register file. Instruction and data memory sit outside the core: both return read data in the same cycle, and the data memory takes a write on the clock edge while the core holds its write strobe.

Any encoding the core does not recognise raises an illegal-instruction flag. In that case the instruction changes nothing except the program counter, which moves on to the next word. Branches add the sign-extended immediate to the address of the branch itself, not to the address of the following word.

Top module: `mini_ls_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears every register. In the first cycle after reset is released, the instruction address is 0.
- R2: Register-form instructions (opcode field bits [31:26] equal to 0x00) take the first source from bits [25:21], the second source from bits [20:16], the destination from bits [15:11] and the function code from bits [10:0].
- R3: Immediate-form instructions take the source register from bits [25:21], the target register from bits [20:16] and a 16-bit immediate from bits [15:0]. The immediate is sign-extended to 32 bits before any use.
- R4: In register form, function 0x020 writes first source plus second source to the destination, and function 0x022 writes first source minus second source.
- R5: Opcode 0x08 writes the source register plus the extended immediate to the target register.
- R6: Opcode 0x23 raises the data read strobe, drives the data address with source plus extended immediate, and writes the returned word into the target register. The data read and write strobes are never high together.
- R7: Opcode 0x2B raises the data write strobe, drives the data address with source plus extended immediate, and drives the write data with the register named in bits [20:16].
- R8: Register 0 always reads as zero, and any write to it is discarded. A copy done as an add with register 0 as the second source yields the source value.
- R9: Opcode 0x04 branches when the source register is zero, and opcode 0x05 branches when it is nonzero. A taken branch loads the program counter with its current value plus the extended immediate. Every other instruction advances the counter by 4.
- R10: Any opcode other than those listed above, or a register-form function code other than 0x020 or 0x022, raises the illegal flag. Such an instruction makes no register write and no data access, and advances the counter by 4.
- R11: The instruction address is always word-aligned (bits [1:0] zero). All data accesses are whole 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data word address |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe, taken at the clock edge |
| dmem_wdata | output | 32 | Data word to store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |
| illegal | output | 1 | Current instruction is not recognised |

## Verification
The test program is built to expose common errors. A taken branch skips exactly one instruction, so a core that adds the offset to PC+4 lands on the wrong word and writes a skipped register. An add-immediate of -3 and a store with a negative displacement will give wrong values or addresses if the immediate is zero-extended. A write aimed at register 0 is followed by a store of register 0 over a non-zero memory word, so a core that keeps the write stores a non-zero value. Two illegal encodings (a bad opcode and a bad function code) each name a destination that is stored later, so a core that still writes on an illegal instruction leaves a changed value in memory. The bench also checks that the flag itself is raised.

// File: rtl/mini_ls_core.sv
module mini_ls_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] imem_addr,
  input  logic [31:0]   imem_rdata,
  output logic [DW-1:0] dmem_addr,
  output logic          dmem_rd,
  output logic          dmem_wr,
  output logic [DW-1:0] dmem_wdata,
  input  logic [DW-1:0] dmem_rdata,
  output logic          illegal
);
  localparam int RW   = 5;
  localparam int NREG = 2 ** RW;

  localparam logic [5:0]  OP_REG  = 6'h00;
  localparam logic [5:0]  OP_ADDI = 6'h08;
  localparam logic [5:0]  OP_LOAD = 6'h23;
  localparam logic [5:0]  OP_STOR = 6'h2B;
  localparam logic [5:0]  OP_BZ   = 6'h04;
  localparam logic [5:0]  OP_BNZ  = 6'h05;
  localparam logic [10:0] FN_ADD  = 11'h020;
  localparam logic [10:0] FN_SUB  = 11'h022;

  logic [DW-1:0] pc;
  logic [DW-1:0] rf [NREG];

  wire [5:0]    op   = imem_rdata[31:26];
  wire [RW-1:0] sa   = imem_rdata[25:21];
  wire [RW-1:0] sb   = imem_rdata[20:16];
  wire [RW-1:0] dr   = imem_rdata[15:11];
  wire [10:0]   fn   = imem_rdata[10:0];
  wire [DW-1:0] immx = {{(DW-16){imem_rdata[15]}}, imem_rdata[15:0]};

  wire is_reg  = op == OP_REG;
  wire is_add  = is_reg && fn == FN_ADD;
  wire is_sub  = is_reg && fn == FN_SUB;
  wire is_addi = op == OP_ADDI;
  wire is_ld   = op == OP_LOAD;
  wire is_st   = op == OP_STOR;
  wire is_bz   = op == OP_BZ;
  wire is_bnz  = op == OP_BNZ;

  wire [DW-1:0] va = (sa == '0) ? '0 : rf[sa];
  wire [DW-1:0] vb = (sb == '0) ? '0 : rf[sb];

  wire [DW-1:0] opnd = is_reg ? vb : immx;
  wire [DW-1:0] sum  = is_sub ? va - opnd : va + opnd;

  wire          wen  = is_add | is_sub | is_addi | is_ld;
  wire [RW-1:0] wdst = is_reg ? dr : sb;
  wire [DW-1:0] wval = is_ld ? dmem_rdata : sum;

  wire take = (is_bz && va == '0) || (is_bnz && va != '0);
  wire [DW-1:0] pc_nx = take ? pc + immx : pc + DW'(4);

  assign illegal    = !(is_add | is_sub | is_addi | is_ld | is_st | is_bz | is_bnz);
  assign imem_addr  = pc;
  assign dmem_addr  = sum;
  assign dmem_rd    = is_ld;
  assign dmem_wr    = is_st;
  assign dmem_wdata = vb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      pc <= pc_nx;
      if (wen && wdst != '0) rf[wdst] <= wval;
    end
  end
endmodule

// File: rtl/mini_ls_core_chk.sv
module mini_ls_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] imem_addr,
  input logic [31:0]   imem_rdata,
  input logic          dmem_rd,
  input logic          dmem_wr,
  input logic          illegal
);
  wire [5:0] op = imem_rdata[31:26];

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == '0);

  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
    (op != 6'h04 && op != 6'h05) |=> imem_addr == $past(imem_addr) + DW'(4));

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!dmem_rd && !dmem_wr));

  p_illegal_step_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |=> imem_addr == $past(imem_addr) + DW'(4));

  p_fetch_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);
endmodule

bind mini_ls_core mini_ls_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .illegal(illegal)
);

// File: tb/sim_mini_ls_core.sv
module sim_mini_ls_core;
  logic        clk = 0;
  logic        rst = 1;
  logic        init_mem = 1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr, illegal;
  logic [31:0] dmem [128];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] ri(input logic [5:0] op, input int s, input int d, input int imm);
    logic [31:0] sv = s, dv = d, iv = imm;
    return {op, sv[4:0], dv[4:0], iv[15:0]};
  endfunction
  function automatic logic [31:0] rr(input int s, input int t, input int d, input int fn);
    logic [31:0] sv = s, tv = t, dv = d, fv = fn;
    return {6'h00, sv[4:0], tv[4:0], dv[4:0], fv[10:0]};
  endfunction

  localparam int NP = 27;
  localparam logic [31:0] PROG [NP] = '{
    ri(6'h08, 0, 1, 5),          //  0 r1=5
    ri(6'h08, 0, 2, -3),         //  4 r2=-3
    rr(1, 2, 3, 'h020),          //  8 r3=r1+r2
    rr(1, 2, 4, 'h022),          // 12 r4=r1-r2
    rr(1, 0, 5, 'h020),          // 16 r5=copy r1
    ri(6'h08, 1, 0, 7),          // 20 write to r0
    ri(6'h2B, 0, 0, 'h100),      // 24 store r0
    ri(6'h23, 0, 6, 'h80),       // 28 load r6
    ri(6'h2B, 0, 3, 'h104),      // 32
    ri(6'h2B, 0, 4, 'h108),      // 36
    ri(6'h2B, 0, 5, 'h10C),      // 40
    ri(6'h2B, 0, 6, 'h110),      // 44
    ri(6'h2B, 0, 2, 'h114),      // 48
    ri(6'h04, 1, 0, 100),        // 52 not taken
    ri(6'h05, 0, 0, 100),        // 56 not taken
    ri(6'h04, 0, 0, 8),          // 60 taken -> 68
    ri(6'h08, 0, 7, 1),          // 64 skipped
    ri(6'h08, 0, 8, 'h55),       // 68
    ri(6'h3F, 0, 9, 1),          // 72 bad opcode
    rr(1, 1, 10, 'h021),         // 76 bad function
    ri(6'h2B, 0, 8, 'h118),      // 80
    ri(6'h2B, 0, 7, 'h11C),      // 84
    ri(6'h2B, 0, 9, 'h120),      // 88
    ri(6'h2B, 0, 10, 'h124),     // 92
    ri(6'h08, 0, 11, 'h200),     // 96
    ri(6'h2B, 11, 1, -4),        // 100 negative displacement
    ri(6'h04, 0, 0, 0)           // 104 halt loop
  };

  localparam int NM = 11;
  localparam logic [31:0] MADDR [NM] = '{'h100, 'h104, 'h108, 'h10C, 'h110, 'h114,
                                         'h118, 'h11C, 'h120, 'h124, 'h1FC};
  localparam logic [31:0] MVAL  [NM] = '{0, 2, 8, 5, 'h12345678, 'hFFFFFFFD,
                                         'h55, 0, 0, 0, 5};

  assign imem_rdata = (imem_addr[7:2] < 6'(NP)) ? PROG[imem_addr[7:2]] : 32'h0;
  assign dmem_rdata = dmem[dmem_addr[8:2]];

  always @(posedge clk) begin
    if (init_mem) begin
      for (int i = 0; i < 128; i++) dmem[i] <= (i == 'h20) ? 32'h12345678 : 32'hA5A5A5A5;
    end else if (dmem_wr) begin
      dmem[dmem_addr[8:2]] <= dmem_wdata;
    end
  end

  mini_ls_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pc(input int k);
    if (k <= 15) return 32'(4 * k);
    if (k <= 25) return 32'(4 * k + 4);
    return 32'd104;
  endfunction

  function automatic bit is_store_pc(input logic [31:0] p);
    return p == 24 || p == 32 || p == 36 || p == 40 || p == 44 || p == 48 ||
           p == 80 || p == 84 || p == 88 || p == 92 || p == 100;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 0);
    rst = 0;
    init_mem = 0;
    for (int k = 0; k < 32; k++) begin
      logic [31:0] p;
      p = exp_pc(k);
      chk("R9 pc sequence", imem_addr, p);
      chk("R7 write strobe", 32'(dmem_wr), 32'(is_store_pc(p)));
      chk("R6 read strobe", 32'(dmem_rd), 32'(p == 28));
      chk("R10 illegal flag", 32'(illegal), 32'(p == 72 || p == 76));
      if (p == 28) chk("R6 load address", dmem_addr, 32'h80);
      if (p == 100) begin
        chk("R3 negative displacement", dmem_addr, 32'h1FC);
        chk("R7 store data", dmem_wdata, 5);
      end
      @(negedge clk);
    end
    for (int m = 0; m < NM; m++)
      chk($sformatf("R4 R8 R10 memory %h", MADDR[m]), dmem[MADDR[m][8:2]], MVAL[m]);
    rst = 1;
    @(negedge clk);
    chk("R1 mid-run reset pc", imem_addr, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 restart step", imem_addr, 4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule